// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a word-addressed store in which every word carries one presence bit, called its tag. The tag reads "full" when the word holds a value that has not yet been consumed and "empty" otherwise. Plain loads and stores move data without looking at the tag. Synchronizing loads and stores use the tag as a lock. A synchronizing load needs a full word; it returns the data and leaves the word empty. A synchronizing store needs an empty word; it writes the data and leaves the word full. Two privileged operations read or overwrite the tag directly, so that software can save and restore the synchronization state.

A synchronizing request that finds the wrong tag does not fail. It is parked in a small age-ordered retry queue together with its requester ID. Any later access that completes on the same address wakes every parked request for that address. Woken requests are retried one per cycle, oldest first, and a retry has priority over a new request. Each completed request produces one response that carries its requester ID. Requests and responses may therefore leave the block in a different order from the one in which they arrived.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every word's tag is empty (0), no response is pending, and a tag read of any address returns 0.
- R2: Op code 0 (plain read) returns the stored word and op code 1 (plain write) stores req_data. Neither ever waits, and neither changes the tag.
- R3: Op code 2 (synchronizing read) on a full word returns the stored word and sets the tag to empty.
- R4: Op code 3 (synchronizing write) on an empty word stores req_data and sets the tag to full.
- R5: A synchronizing read of an empty word gives no response and no state change. It is parked and completes only after the word has become full.
- R6: A synchronizing write to a full word gives no response and no state change. It is parked and completes only after the word has become empty.
- R7: Op code 4 (tag read) returns the tag in rsp_data bit 0 with all other bits 0. Op code 5 (tag write) sets the tag to req_data bit 0 and leaves the data unchanged. Neither ever waits.
- R8: Every completed request gives exactly one response, with rsp_valid high in the cycle after the completing attempt and rsp_id equal to its requester ID. Completed write-type operations (op codes 1, 3 and 5) respond with all-zero data.
- R9: A completed access to an address wakes all parked requests for that address. Woken requests are retried one per cycle, oldest arrival first. A retry that still finds the wrong tag stays parked in its place until the next wake.
- R10: In any cycle in which a woken request exists, req_ready is low and that request is attempted instead of a new one.
- R11: When the retry queue is full, req_ready is low for a request that would have to wait. A request that would complete is still accepted.
- R12: Op codes 6 and 7 change no data and no tag, never wait, and respond with all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_op | input | 3 | Operation code (see requirements) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Write data, or the new tag in bit 0 for a tag write |
| req_id | input | ID_W | Requester ID returned with the response |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Read data, tag, or zero for writes |
| rsp_id | output | ID_W | Requester ID of the completed request |

## Verification
The collision that matters is a woken retry and a fresh request competing for the single access slot in the same cycle. The bench provokes it by holding a new request on req_valid in the cycle right after an access that releases parked requests. It then checks that req_ready stays low until every woken entry has been tried, and that the responses come out in the order the reference model predicts. A second overlap happens when the queue is full: a request that would wait arrives in the same cycle as one that would complete, so req_ready must turn down only the first. A behavioural model, built from queues and compared on every clock, judges both cases.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

  typedef enum logic [2:0] {
    OP_RD  = 3'd0,
    OP_WR  = 3'd1,
    OP_SRD = 3'd2,
    OP_SWR = 3'd3,
    OP_TRD = 3'd4,
    OP_TWR = 3'd5
  } fe_op_e;

  // A synchronizing access must wait when the tag is in the wrong state.
  function automatic logic op_must_wait(input logic [2:0] op, input logic tag);
    return ((op == OP_SRD) && !tag) || ((op == OP_SWR) && tag);
  endfunction

endpackage

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 data_we,
  input  logic [DATA_W-1:0]    data_wr,
  input  logic                 tag_we,
  input  logic                 tag_wr,
  output logic [DATA_W-1:0]    data_rd,
  output logic                 tag_rd,
  output logic [(1<<ADDR_W)-1:0] tag_vec
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  tag_q;

  // Data words carry no reset.
  always_ff @(posedge clk) begin
    if (data_we) begin
      mem_q[addr] <= data_wr;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= 1'b0;
      end else if (tag_we && (addr == ADDR_W'(g))) begin
        tag_q[g] <= tag_wr;
      end
    end
  end

  assign data_rd = mem_q[addr];
  assign tag_rd  = tag_q[addr];
  assign tag_vec = tag_q;

endmodule

// File: rtl/fe_access_unit.sv
module fe_access_unit #(
  parameter int DATA_W = 64
) (
  input  logic              att_valid,
  input  logic [2:0]        att_op,
  input  logic [DATA_W-1:0] att_data,
  input  logic [DATA_W-1:0] cur_data,
  input  logic              cur_tag,
  output logic              done,
  output logic              data_we,
  output logic              tag_we,
  output logic              tag_new,
  output logic [DATA_W-1:0] rsp_data
);
  import fe_mem_pkg::*;

  always_comb begin
    done     = 1'b0;
    data_we  = 1'b0;
    tag_we   = 1'b0;
    tag_new  = 1'b0;
    rsp_data = '0;
    if (att_valid) begin
      unique case (att_op)
        OP_RD: begin
          done     = 1'b1;
          rsp_data = cur_data;
        end
        OP_WR: begin
          done    = 1'b1;
          data_we = 1'b1;
        end
        OP_SRD: begin
          if (cur_tag) begin
            done     = 1'b1;
            rsp_data = cur_data;
            tag_we   = 1'b1;
            tag_new  = 1'b0;
          end
        end
        OP_SWR: begin
          if (!cur_tag) begin
            done    = 1'b1;
            data_we = 1'b1;
            tag_we  = 1'b1;
            tag_new = 1'b1;
          end
        end
        OP_TRD: begin
          done        = 1'b1;
          rsp_data[0] = cur_tag;
        end
        OP_TWR: begin
          done    = 1'b1;
          tag_we  = 1'b1;
          tag_new = att_data[0];
        end
        default: begin
          done = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/fe_retry_queue.sv
module fe_retry_queue #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [2:0]        push_op,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ID_W-1:0]   push_id,
  input  logic              take,
  input  logic              take_done,
  input  logic              wake_valid,
  input  logic [ADDR_W-1:0] wake_addr,
  output logic              any_woken,
  output logic              full,
  output logic [2:0]        sel_op,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_data,
  output logic [ID_W-1:0]   sel_id
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  v_q, w_q, v_n, w_n;
  logic [2:0]        op_q   [DEPTH];
  logic [2:0]        op_n   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_n [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DATA_W-1:0] data_n [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [ID_W-1:0]   id_n   [DEPTH];
  logic [IDX_W-1:0]  sel_idx;
  logic              placed;

  // Oldest woken entry: lowest index wins (index 0 holds the oldest).
  always_comb begin
    sel_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (v_q[i] && w_q[i]) begin
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign any_woken = |(v_q & w_q);
  assign full      = v_q[DEPTH-1];
  assign sel_op    = op_q[sel_idx];
  assign sel_addr  = addr_q[sel_idx];
  assign sel_data  = data_q[sel_idx];
  assign sel_id    = id_q[sel_idx];

  always_comb begin
    v_n    = v_q;
    w_n    = w_q;
    op_n   = op_q;
    addr_n = addr_q;
    data_n = data_q;
    id_n   = id_q;
    placed = 1'b0;

    // Stage 1: remove a completed retry, keeping arrival order compact.
    if (take && take_done) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(sel_idx)) begin
          if (i < DEPTH - 1) begin
            v_n[i]    = v_q[(i < DEPTH - 1) ? i + 1 : i];
            w_n[i]    = w_q[(i < DEPTH - 1) ? i + 1 : i];
            op_n[i]   = op_q[(i < DEPTH - 1) ? i + 1 : i];
            addr_n[i] = addr_q[(i < DEPTH - 1) ? i + 1 : i];
            data_n[i] = data_q[(i < DEPTH - 1) ? i + 1 : i];
            id_n[i]   = id_q[(i < DEPTH - 1) ? i + 1 : i];
          end else begin
            v_n[i] = 1'b0;
            w_n[i] = 1'b0;
          end
        end
      end
    end else if (take) begin
      w_n[sel_idx] = 1'b0;
    end

    // Stage 2: a completed access wakes every waiter on its address.
    if (wake_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (v_n[i] && (addr_n[i] == wake_addr)) begin
          w_n[i] = 1'b1;
        end
      end
    end

    // Stage 3: append a newly blocked request at the tail.
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!placed && !v_n[i]) begin
          placed    = 1'b1;
          v_n[i]    = 1'b1;
          w_n[i]    = 1'b0;
          op_n[i]   = push_op;
          addr_n[i] = push_addr;
          data_n[i] = push_data;
          id_n[i]   = push_id;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      w_q <= '0;
    end else begin
      v_q <= v_n;
      w_q <= w_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (v_n[i]) begin
        op_q[i]   <= op_n[i];
        addr_q[i] <= addr_n[i];
        data_q[i] <= data_n[i];
        id_q[i]   <= id_n[i];
      end
    end
  end

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ID_W-1:0]   rsp_id
);
  import fe_mem_pkg::*;

  localparam int WORDS = 1 << ADDR_W;

  logic              rst_meta, rst_sync;
  logic              any_woken, q_full;
  logic [2:0]        q_op;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  logic [ID_W-1:0]   q_id;
  logic              att_valid;
  logic [2:0]        att_op;
  logic [ADDR_W-1:0] att_addr;
  logic [DATA_W-1:0] att_data;
  logic [ID_W-1:0]   att_id;
  logic              att_done;
  logic [DATA_W-1:0] cur_data, att_rsp;
  logic              cur_tag;
  logic              data_we, tag_we, tag_new;
  logic [WORDS-1:0]  tag_vec;
  logic              new_waits, accept, push;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [ID_W-1:0]   rsp_id_q;

  // Reset: asserted asynchronously, released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign new_waits = op_must_wait(req_op, tag_vec[req_addr]);
  assign req_ready = rst_sync && !any_woken && (!q_full || !new_waits);
  assign accept    = req_valid && req_ready;

  // A woken retry takes the single access slot ahead of new traffic.
  always_comb begin
    if (any_woken) begin
      att_valid = 1'b1;
      att_op    = q_op;
      att_addr  = q_addr;
      att_data  = q_data;
      att_id    = q_id;
    end else begin
      att_valid = accept;
      att_op    = req_op;
      att_addr  = req_addr;
      att_data  = req_data;
      att_id    = req_id;
    end
  end

  assign push = accept && !att_done;

  fe_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_sync),
    .addr    (att_addr),
    .data_we (data_we),
    .data_wr (att_data),
    .tag_we  (tag_we),
    .tag_wr  (tag_new),
    .data_rd (cur_data),
    .tag_rd  (cur_tag),
    .tag_vec (tag_vec)
  );

  fe_access_unit #(.DATA_W(DATA_W)) i_access (
    .att_valid (att_valid),
    .att_op    (att_op),
    .att_data  (att_data),
    .cur_data  (cur_data),
    .cur_tag   (cur_tag),
    .done      (att_done),
    .data_we   (data_we),
    .tag_we    (tag_we),
    .tag_new   (tag_new),
    .rsp_data  (att_rsp)
  );

  fe_retry_queue #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .DEPTH  (QDEPTH)
  ) i_queue (
    .clk        (clk),
    .rst_n      (rst_sync),
    .push       (push),
    .push_op    (req_op),
    .push_addr  (req_addr),
    .push_data  (req_data),
    .push_id    (req_id),
    .take       (any_woken),
    .take_done  (att_done),
    .wake_valid (att_valid && att_done),
    .wake_addr  (att_addr),
    .any_woken  (any_woken),
    .full       (q_full),
    .sel_op     (q_op),
    .sel_addr   (q_addr),
    .sel_data   (q_data),
    .sel_id     (q_id)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= att_done;
    end
  end

  always_ff @(posedge clk) begin
    if (att_done) begin
      rsp_data_q <= att_rsp;
      rsp_id_q   <= att_id;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_id    = rsp_id_q;

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   att_valid,
  input logic [2:0]             att_op,
  input logic [ADDR_W-1:0]      att_addr,
  input logic                   att_done,
  input logic [(1<<ADDR_W)-1:0] tag_vec,
  input logic                   rsp_valid,
  input logic                   req_ready,
  input logic                   any_woken
);
  import fe_mem_pkg::*;

  // R2: plain accesses leave every tag as it was
  a_r2_plain_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (att_valid && att_done && (att_op == OP_RD || att_op == OP_WR)) |=> (tag_vec == $past(tag_vec)));

  // R3: a completed synchronizing read leaves the word empty
  a_r3_srd_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (att_valid && att_done && att_op == OP_SRD) |=> !tag_vec[$past(att_addr)]);

  // R4: a completed synchronizing write leaves the word full
  a_r4_swr_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (att_valid && att_done && att_op == OP_SWR) |=> tag_vec[$past(att_addr)]);

  // R5: synchronizing read of an empty word cannot complete
  a_r5_srd_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (att_valid && att_op == OP_SRD && !tag_vec[att_addr]) |-> !att_done);

  // R6: synchronizing write to a full word cannot complete
  a_r6_swr_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (att_valid && att_op == OP_SWR && tag_vec[att_addr]) |-> !att_done);

  // R8: one response per completion, one cycle later
  a_r8_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(att_valid && att_done)));

  // R10: a woken retry keeps new requests out
  a_r10_retry_first: assert property (@(posedge clk) disable iff (!rst_n)
    any_woken |-> !req_ready);

endmodule

bind fe_sync_mem fe_sync_mem_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync),
  .att_valid (att_valid),
  .att_op    (att_op),
  .att_addr  (att_addr),
  .att_done  (att_done),
  .tag_vec   (tag_vec),
  .rsp_valid (rsp_valid),
  .req_ready (req_ready),
  .any_woken (any_woken)
);

// File: tb/test_fe_sync_mem.sv
module test_fe_sync_mem;
  localparam int AW = 4;
  localparam int DW = 64;
  localparam int IW = 4;
  localparam int QD = 4;
  localparam int WORDS = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [IW-1:0] req_id;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [IW-1:0] rsp_id;

  fe_sync_mem #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .QDEPTH(QD)) i_fe_sync_mem (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_id(rsp_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  string label = "R1";

  // Behavioural reference model
  logic [DW-1:0] m_mem [WORDS];
  bit            m_tag [WORDS];
  int            q_op[$];
  int            q_addr[$];
  logic [DW-1:0] q_data[$];
  int            q_id[$];
  bit            q_wake[$];
  bit            e_valid = 0;
  logic [DW-1:0] e_data = '0;
  int            e_id = 0;

  function automatic bit waits(int op, bit tag);
    return (op == 2 && !tag) || (op == 3 && tag);
  endfunction

  task automatic check(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual %h expected %h", label, what, act, exp);
    end
  endtask

  // Returns 1 when the model completes the access.
  function automatic bit model_access(int op, int addr, logic [DW-1:0] d, int id);
    if (waits(op, m_tag[addr])) return 0;
    e_valid = 1; e_id = id; e_data = '0;
    case (op)
      0: e_data = m_mem[addr];
      1: m_mem[addr] = d;
      2: begin e_data = m_mem[addr]; m_tag[addr] = 0; end
      3: begin m_mem[addr] = d; m_tag[addr] = 1; end
      4: e_data = {{(DW-1){1'b0}}, m_tag[addr]};
      5: m_tag[addr] = d[0];
      default: ;
    endcase
    foreach (q_addr[k]) if (q_addr[k] == addr) q_wake[k] = 1;
    return 1;
  endfunction

  // One clock: compare outputs, drive inputs, step the model.
  task automatic cyc(bit v, int op, int addr, logic [DW-1:0] d, int id, output bit acc);
    int  wk;
    bit  exp_ready;
    @(negedge clk);
    check(rsp_valid === e_valid, "rsp_valid", DW'(rsp_valid), DW'(e_valid));
    if (e_valid) begin
      check(rsp_data === e_data, "rsp_data", rsp_data, e_data);
      check(rsp_id === IW'(e_id), "rsp_id", DW'(rsp_id), DW'(e_id));
    end
    req_valid = v; req_op = 3'(op); req_addr = AW'(addr); req_data = d; req_id = IW'(id);
    #1;
    wk = -1;
    foreach (q_wake[k]) if (wk < 0 && q_wake[k]) wk = k;
    exp_ready = (wk < 0) && (q_op.size() < QD || !waits(op, m_tag[addr]));
    check(req_ready === exp_ready, "req_ready", DW'(req_ready), DW'(exp_ready));
    acc = v && exp_ready;
    e_valid = 0;
    if (wk >= 0) begin
      int op2 = q_op[wk]; int a2 = q_addr[wk]; logic [DW-1:0] d2 = q_data[wk]; int id2 = q_id[wk];
      q_wake[wk] = 0;
      if (model_access(op2, a2, d2, id2)) begin
        q_op.delete(wk); q_addr.delete(wk); q_data.delete(wk); q_id.delete(wk); q_wake.delete(wk);
        foreach (q_addr[k]) if (q_addr[k] == a2) q_wake[k] = 1;
      end
    end else if (acc) begin
      if (!model_access(op, addr, d, id)) begin
        q_op.push_back(op); q_addr.push_back(addr); q_data.push_back(d);
        q_id.push_back(id); q_wake.push_back(0);
      end
    end
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, a);
  endtask

  task automatic send(int op, int addr, logic [DW-1:0] d, int id);
    bit a = 0;
    while (!a) cyc(1, op, addr, d, id, a);
  endtask

  initial begin
    bit a;
    req_valid = 0; req_op = 0; req_addr = 0; req_data = 0; req_id = 0;
    for (int i = 0; i < WORDS; i++) begin m_mem[i] = '0; m_tag[i] = 0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: all tags empty after reset
    label = "R1";
    idle(1);
    for (int i = 0; i < WORDS; i++) send(4, i, '0, i);
    idle(1);

    // R2: plain write/read, tag untouched
    label = "R2";
    send(1, 1, 64'h1111_2222_3333_4444, 1);
    send(0, 1, '0, 2);
    send(4, 1, '0, 3);
    idle(1);

    // R4 then R3
    label = "R4";
    send(3, 2, 64'hA5A5_0000_FFFF_0001, 4);
    send(4, 2, '0, 5);
    label = "R3";
    send(2, 2, '0, 6);
    send(4, 2, '0, 7);
    idle(1);

    // R5: read waits on empty, released by a write
    label = "R5";
    send(2, 3, '0, 8);
    idle(3);
    send(3, 3, 64'hDEAD_BEEF_0000_0003, 9);
    idle(2);

    // R6: write waits on full, released by a read
    label = "R6";
    send(3, 2, 64'h0000_0000_0000_0022, 10);
    send(3, 2, 64'h0000_0000_0000_0033, 11);
    idle(2);
    send(2, 2, '0, 12);
    idle(2);
    send(0, 2, '0, 13);
    idle(1);

    // R9: two waiters, oldest first, second re-parks
    label = "R9";
    send(2, 4, '0, 1);
    send(2, 4, '0, 2);
    send(3, 4, 64'h44, 3);
    idle(3);
    send(3, 4, 64'h45, 4);
    idle(2);

    // R10: new request offered while a retry is woken
    label = "R10";
    send(2, 5, '0, 5);
    send(3, 5, 64'h55, 6);
    send(1, 6, 64'h66, 7);
    idle(2);

    // R11: full queue refuses a waiter, accepts a completer
    label = "R11";
    for (int i = 0; i < QD; i++) send(2, 7 + i, '0, i);
    cyc(1, 2, 11, '0, 9, a);
    send(1, 12, 64'hC12, 10);
    for (int i = 0; i < QD; i++) begin
      send(3, 7 + i, 64'h700 + i, 11);
      idle(2);
    end

    // R7: tag write / tag read
    label = "R7";
    send(1, 13, 64'h1313, 1);
    send(5, 13, 64'hFFFF_FFFF_FFFF_FFFF, 2);
    send(4, 13, '0, 3);
    send(2, 13, '0, 4);
    send(5, 13, 64'h0, 5);
    send(4, 13, '0, 6);
    idle(1);

    // R8: write acknowledgement carries zero data and its id
    label = "R8";
    send(1, 14, 64'h9999, 15);
    send(0, 14, '0, 14);
    idle(1);

    // R12: unused op codes do nothing
    label = "R12";
    send(6, 1, 64'hFFFF, 3);
    send(7, 1, 64'h1, 4);
    send(0, 1, '0, 5);
    send(4, 1, '0, 6);
    idle(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired in %s actual %0d expected %0d", label, 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule